// File: doc/BRIEF.md
# Accumulator ALU with Registered Status

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. Each cycle it takes an operation code, a register operand (accumulator or index register), a memory operand and the current status byte. It produces a result byte and a new status byte. The operation is worked out combinationally. The result and status are captured in output registers on the rising clock edge, and only when the write strobe is high. Surrounding sequencing logic feeds the registered status back as the next `statusIn`, and routes `resultOut` to whichever register the instruction names.

The unit covers binary add and subtract through carry, compare, the three bitwise operations and bit test. It also covers increment and decrement, the four single-bit shifts and rotates, loads and register transfers, and the flag set and clear operations. Subtraction adds the ones complement of the memory operand plus the carry. The decimal flag is kept in the status byte but never changes arithmetic. Operand fetch and address generation belong elsewhere.

Top module: `alu_top`

## Requirements
- R1: Status bits are laid out as C=bit 0, Z=bit 1, I=bit 2, D=bit 3, B=bit 4, V=bit 6 and N=bit 7. An asynchronous active-low reset clears `resultOut` and `statusOut` to 0x00.
- R2: The outputs take the new result and status one clock edge after `wrEn` is sampled high. While `wrEn` is low, both outputs hold their values.
- R3: Add (opSel 0) gives R = (A + M + C) mod 256, with A=`regIn`, M=`memIn` and C=`statusIn` bit 0. C is set when the 9-bit sum exceeds 0xFF. V is set when A and M have the same sign bit and R's sign differs from A's. Z and N follow R.
- R4: Subtract (opSel 1) gives R = (A + (0xFF − M) + C) mod 256. C is set when that 9-bit sum exceeds 0xFF. V is set when A and M have different sign bits and R's sign differs from A's. Z and N follow R.
- R5: Compare (opSel 2) returns `regIn` unchanged as the result. It sets C when `regIn` ≥ `memIn` as unsigned values, takes Z and N from the 8-bit difference `regIn` − `memIn`, and leaves V as it came in.
- R6: AND (opSel 3), OR (opSel 4) and XOR (opSel 5) combine `regIn` with `memIn` and update only Z and N.
- R7: Bit test (opSel 6) returns `regIn` unchanged as the result. It sets Z when (`regIn` AND `memIn`) is zero, and copies `memIn` bit 7 into N and `memIn` bit 6 into V.
- R8: Increment (opSel 7) and decrement (opSel 8) act on `regIn` modulo 256 and update only Z and N.
- R9: The shifts and rotates act on `regIn`. Shift left (opSel 9) moves bit 7 into C and fills with 0. Shift right (opSel 10) moves bit 0 into C and fills with 0. Rotate left (opSel 11) feeds the old C into bit 0, and rotate right (opSel 12) feeds the old C into bit 7; both also move the outgoing bit into C. Z and N follow the result.
- R10: Load (opSel 13) passes `memIn` and transfer (opSel 14) passes `regIn`; both update only Z and N. Transfer to the stack pointer (opSel 15) passes `regIn` and changes no flag.
- R11: The flag operations return `regIn` and change one flag each: clear C (16), set C (17), clear I (18), set I (19), clear D (20), set D (21), clear V (22).
- R12: Status bit 5, and every flag an operation does not name, pass from `statusIn` unchanged. Codes 23 to 31 return `regIn` and pass the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opSel | input | 5 | Operation code |
| regIn | input | 8 | Register operand |
| memIn | input | 8 | Memory operand |
| statusIn | input | 8 | Incoming status byte |
| wrEn | input | 1 | Capture strobe for result and status |
| resultOut | output | 8 | Registered result |
| statusOut | output | 8 | Registered status byte |

## Verification
The hardest cases to reach are the signed-overflow and carry corners of add, subtract and compare. These include operands that straddle 0x7F/0x80, equal operands in compare, and a borrow out of zero, each combined with both carry-in values. The stimulus sweeps every `regIn`/`memIn` pair for add and subtract, and varies the carry-in and the other status bits with the pair. Compare gets a dense sweep: every `regIn` against every third `memIn`. A pseudo-random mix of all codes, write strobes and status patterns then checks that untouched flags and bit 5 survive.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_I = 2;
  localparam int unsigned FLAG_D = 3;
  localparam int unsigned FLAG_V = 6;
  localparam int unsigned FLAG_N = 7;

  typedef enum logic [4:0] {
    OP_ADC   = 5'd0,
    OP_SBC   = 5'd1,
    OP_CMP   = 5'd2,
    OP_AND   = 5'd3,
    OP_OR    = 5'd4,
    OP_XOR   = 5'd5,
    OP_BIT   = 5'd6,
    OP_INC   = 5'd7,
    OP_DEC   = 5'd8,
    OP_SHL   = 5'd9,
    OP_SHR   = 5'd10,
    OP_ROL   = 5'd11,
    OP_ROR   = 5'd12,
    OP_LOAD  = 5'd13,
    OP_XFER  = 5'd14,
    OP_XSP   = 5'd15,
    OP_CLRC  = 5'd16,
    OP_SETC  = 5'd17,
    OP_CLRI  = 5'd18,
    OP_SETI  = 5'd19,
    OP_CLRD  = 5'd20,
    OP_SETD  = 5'd21,
    OP_CLRV  = 5'd22
  } aluOp_e;

  typedef enum logic [3:0] {
    RS_SUM, RS_AND, RS_OR, RS_XOR, RS_INC, RS_DEC,
    RS_SHL, RS_SHR, RS_MEM, RS_REG
  } resSel_e;

  typedef struct packed {
    resSel_e           resSel;
    logic              invertMem;
    logic              carryFromStatus;
    logic              forceCarry;
    logic              rotateIn;
    logic              keepReg;
    logic              updC;
    logic              updZN;
    logic              updV;
    logic              bitTest;
    logic [STAT_W-1:0] setMask;
    logic [STAT_W-1:0] clrMask;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [4:0] opSel,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    strobe.resSel = RS_REG;
    case (aluOp_e'(opSel))
      OP_ADC: begin
        strobe.resSel = RS_SUM;
        strobe.carryFromStatus = 1'b1;
        strobe.updC = 1'b1; strobe.updZN = 1'b1; strobe.updV = 1'b1;
      end
      OP_SBC: begin
        strobe.resSel = RS_SUM;
        strobe.invertMem = 1'b1;
        strobe.carryFromStatus = 1'b1;
        strobe.updC = 1'b1; strobe.updZN = 1'b1; strobe.updV = 1'b1;
      end
      OP_CMP: begin
        strobe.resSel = RS_SUM;
        strobe.invertMem = 1'b1;
        strobe.forceCarry = 1'b1;
        strobe.keepReg = 1'b1;
        strobe.updC = 1'b1; strobe.updZN = 1'b1;
      end
      OP_AND: begin strobe.resSel = RS_AND; strobe.updZN = 1'b1; end
      OP_OR:  begin strobe.resSel = RS_OR;  strobe.updZN = 1'b1; end
      OP_XOR: begin strobe.resSel = RS_XOR; strobe.updZN = 1'b1; end
      OP_BIT: begin
        strobe.resSel = RS_AND;
        strobe.keepReg = 1'b1;
        strobe.updZN = 1'b1;
        strobe.bitTest = 1'b1;
      end
      OP_INC: begin strobe.resSel = RS_INC; strobe.updZN = 1'b1; end
      OP_DEC: begin strobe.resSel = RS_DEC; strobe.updZN = 1'b1; end
      OP_SHL: begin strobe.resSel = RS_SHL; strobe.updC = 1'b1; strobe.updZN = 1'b1; end
      OP_SHR: begin strobe.resSel = RS_SHR; strobe.updC = 1'b1; strobe.updZN = 1'b1; end
      OP_ROL: begin
        strobe.resSel = RS_SHL; strobe.rotateIn = 1'b1;
        strobe.updC = 1'b1; strobe.updZN = 1'b1;
      end
      OP_ROR: begin
        strobe.resSel = RS_SHR; strobe.rotateIn = 1'b1;
        strobe.updC = 1'b1; strobe.updZN = 1'b1;
      end
      OP_LOAD: begin strobe.resSel = RS_MEM; strobe.updZN = 1'b1; end
      OP_XFER: begin strobe.resSel = RS_REG; strobe.updZN = 1'b1; end
      OP_XSP:  strobe.resSel = RS_REG;
      OP_CLRC: strobe.clrMask[FLAG_C] = 1'b1;
      OP_SETC: strobe.setMask[FLAG_C] = 1'b1;
      OP_CLRI: strobe.clrMask[FLAG_I] = 1'b1;
      OP_SETI: strobe.setMask[FLAG_I] = 1'b1;
      OP_CLRD: strobe.clrMask[FLAG_D] = 1'b1;
      OP_SETD: strobe.setMask[FLAG_D] = 1'b1;
      OP_CLRV: strobe.clrMask[FLAG_V] = 1'b1;
      default: strobe.resSel = RS_REG;
    endcase
  end

endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] regIn,
  input  logic [DATA_W-1:0] memIn,
  input  logic [STAT_W-1:0] statusIn,
  output logic [DATA_W-1:0] resNext,
  output logic [STAT_W-1:0] statusNext
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] opB;
  logic              carryIn;
  logic              shiftIn;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] aluVal;
  logic              carryOut;
  logic              zeroFlag;
  logic              negFlag;
  logic              ovfFlag;
  logic [STAT_W-1:0] flagsMid;

  assign opB     = strobe.invertMem ? ~memIn : memIn;
  assign carryIn = strobe.carryFromStatus ? statusIn[FLAG_C] : strobe.forceCarry;
  assign shiftIn = strobe.rotateIn & statusIn[FLAG_C];
  assign sum     = {1'b0, regIn} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    carryOut = statusIn[FLAG_C];
    case (strobe.resSel)
      RS_SUM: begin aluVal = sum[MSB:0]; carryOut = sum[DATA_W]; end
      RS_AND: aluVal = regIn & memIn;
      RS_OR:  aluVal = regIn | memIn;
      RS_XOR: aluVal = regIn ^ memIn;
      RS_INC: aluVal = regIn + {{(DATA_W-1){1'b0}}, 1'b1};
      RS_DEC: aluVal = regIn - {{(DATA_W-1){1'b0}}, 1'b1};
      RS_SHL: begin aluVal = {regIn[MSB-1:0], shiftIn}; carryOut = regIn[MSB]; end
      RS_SHR: begin aluVal = {shiftIn, regIn[MSB:1]}; carryOut = regIn[0]; end
      RS_MEM: aluVal = memIn;
      default: aluVal = regIn;
    endcase
  end

  assign zeroFlag = (aluVal == '0);
  assign negFlag  = aluVal[MSB];
  assign ovfFlag  = (regIn[MSB] == opB[MSB]) && (aluVal[MSB] != regIn[MSB]);

  always_comb begin
    flagsMid = statusIn;
    if (strobe.updC)  flagsMid[FLAG_C] = carryOut;
    if (strobe.updZN) begin
      flagsMid[FLAG_Z] = zeroFlag;
      flagsMid[FLAG_N] = negFlag;
    end
    if (strobe.updV)  flagsMid[FLAG_V] = ovfFlag;
    if (strobe.bitTest) begin
      flagsMid[FLAG_N] = memIn[MSB];
      flagsMid[FLAG_V] = memIn[MSB-1];
    end
  end

  assign statusNext = (flagsMid | strobe.setMask) & ~strobe.clrMask;
  assign resNext    = strobe.keepReg ? regIn : aluVal;

endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        opSel,
  input  logic [DATA_W-1:0] regIn,
  input  logic [DATA_W-1:0] memIn,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              wrEn,
  output logic [DATA_W-1:0] resultOut,
  output logic [STAT_W-1:0] statusOut
);

  aluStrobe_t        strobe;
  logic [DATA_W-1:0] resNext;
  logic [STAT_W-1:0] statusNext;

  alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu_dp #(.DATA_W(DATA_W)) u_dp (
    .strobe     (strobe),
    .regIn      (regIn),
    .memIn      (memIn),
    .statusIn   (statusIn),
    .resNext    (resNext),
    .statusNext (statusNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      statusOut <= '0;
    end else if (wrEn) begin
      resultOut <= resNext;
      statusOut <= statusNext;
    end
  end

endmodule

// File: rtl/alu_top_checker.sv
module alu_top_checker
  import alu_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [4:0] opSel,
  input logic [7:0] regIn,
  input logic [7:0] memIn,
  input logic [7:0] statusIn,
  input logic       wrEn,
  input logic [7:0] resultOut,
  input logic [7:0] statusOut
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(resultOut) && $stable(statusOut)));

  assert_spare_bit_R12: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (statusOut[5] == $past(statusIn[5])));

  assert_cmp_keeps_v_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opSel == OP_CMP) |=>
      (statusOut[6] == $past(statusIn[6]) && resultOut == $past(regIn)));

  assert_bit_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opSel == OP_BIT) |=>
      (statusOut[7:6] == $past(memIn[7:6]) && resultOut == $past(regIn)));

  assert_logic_zn_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR)) |=>
      (statusOut[1] == (resultOut == 8'h00) && statusOut[7] == resultOut[7]));

  assert_sp_xfer_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opSel == OP_XSP) |=>
      (statusOut == $past(statusIn) && resultOut == $past(regIn)));

endmodule

bind alu_top alu_top_checker u_chk (.*);

// File: tb/alu_top_bench.sv
module alu_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] regIn = '0;
  logic [7:0] memIn = '0;
  logic [7:0] statusIn = '0;
  logic       wrEn = 1'b0;
  logic [7:0] resultOut;
  logic [7:0] statusOut;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  logic [7:0] expRes = '0;
  logic [7:0] expSt = '0;
  string expTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_top u_alu_top (
    .clk(clk), .rstN(rstN), .opSel(opSel), .regIn(regIn), .memIn(memIn),
    .statusIn(statusIn), .wrEn(wrEn), .resultOut(resultOut), .statusOut(statusOut)
  );

  function automatic logic [15:0] refModel(int op, int r, int m, int s);
    int res = r;
    int st = s;
    int t;
    bit zn = 1'b0;
    case (op)
      0: begin
        t = r + m + (s & 1); res = t & 255;
        st = st & ~'h41;
        if (t > 255) st = st | 1;
        if (((r ^ m) & 128) == 0 && ((r ^ res) & 128) != 0) st = st | 64;
        zn = 1'b1;
      end
      1: begin
        t = r + (255 - m) + (s & 1); res = t & 255;
        st = st & ~'h41;
        if (t > 255) st = st | 1;
        if (((r ^ m) & 128) != 0 && ((r ^ res) & 128) != 0) st = st | 64;
        zn = 1'b1;
      end
      2: begin
        t = (r - m) & 255;
        st = st & ~'h83;
        if (r >= m) st = st | 1;
        if (t == 0) st = st | 2;
        st = st | (t & 128);
      end
      3: begin res = r & m; zn = 1'b1; end
      4: begin res = r | m; zn = 1'b1; end
      5: begin res = r ^ m; zn = 1'b1; end
      6: st = (st & ~'hC2) | (m & 'hC0) | (((r & m) == 0) ? 2 : 0);
      7: begin res = (r + 1) & 255; zn = 1'b1; end
      8: begin res = (r + 255) & 255; zn = 1'b1; end
      9:  begin res = (r << 1) & 255; st = (st & ~1) | (r >> 7); zn = 1'b1; end
      10: begin res = r >> 1; st = (st & ~1) | (r & 1); zn = 1'b1; end
      11: begin res = ((r << 1) | (s & 1)) & 255; st = (st & ~1) | (r >> 7); zn = 1'b1; end
      12: begin res = (r >> 1) | ((s & 1) << 7); st = (st & ~1) | (r & 1); zn = 1'b1; end
      13: begin res = m; zn = 1'b1; end
      14: zn = 1'b1;
      16: st = st & ~1;
      17: st = st | 1;
      18: st = st & ~4;
      19: st = st | 4;
      20: st = st & ~8;
      21: st = st | 8;
      22: st = st & ~64;
      default: ;
    endcase
    if (zn) st = (st & ~'h82) | ((res == 0) ? 2 : 0) | (res & 128);
    refModel = {res[7:0], st[7:0]};
  endfunction

  function automatic string tagFor(int op);
    case (op)
      0: tagFor = "R3";
      1: tagFor = "R4";
      2: tagFor = "R5";
      3, 4, 5: tagFor = "R6";
      6: tagFor = "R7";
      7, 8: tagFor = "R8";
      9, 10, 11, 12: tagFor = "R9";
      13, 14, 15: tagFor = "R10";
      16, 17, 18, 19, 20, 21, 22: tagFor = "R11";
      default: tagFor = "R12";
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (resultOut !== expRes || statusOut !== expSt) begin
      errors++;
      $display("FAIL %s result %02h expected %02h status %02h expected %02h",
               expTag, resultOut, expRes, statusOut, expSt);
    end
  endtask

  task automatic step(int op, int r, int m, int s, bit we, string tag);
    @(negedge clk);
    compare();
    opSel = op[4:0]; regIn = r[7:0]; memIn = m[7:0]; statusIn = s[7:0]; wrEn = we;
    if (we) begin
      {expRes, expSt} = refModel(op, r, m, s);
      expTag = tag;
    end else begin
      expTag = "R2";
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                       // R1 reset state while reset held
    rstN = 1'b1;
    // R1 outputs still zero first cycle after release (checked by first step)
    step(0, 'h50, 'h50, 'h00, 1, "R3");   // signed overflow, N
    step(0, 'hFF, 'h01, 'h00, 1, "R3");   // carry and zero
    step(0, 'h7F, 'h00, 'h01, 1, "R3");   // carry-in overflows
    step(1, 'h50, 'hB0, 'h01, 1, "R4");   // signs differ, overflow
    step(1, 'h00, 'h01, 'h01, 1, "R4");   // borrow out of zero
    step(1, 'h05, 'h05, 'h00, 1, "R4");   // no carry-in
    step(2, 'h40, 'h40, 'h40, 1, "R5");   // equal, V kept
    step(2, 'h10, 'h20, 'h00, 1, "R5");   // below
    step(3, 'hF0, 'h0F, 'h00, 1, "R6");   // AND zero
    step(4, 'h80, 'h01, 'h41, 1, "R6");   // OR negative, C V kept
    step(5, 'hAA, 'hAA, 'hFF, 1, "R6");   // XOR zero
    step(6, 'h0F, 'hC0, 'h00, 1, "R7");   // zero, N V copied
    step(6, 'hFF, 'h01, 'hC0, 1, "R7");   // nonzero, N V cleared
    step(7, 'hFF, 'h00, 'h01, 1, "R8");   // wrap to zero
    step(8, 'h00, 'h00, 'h00, 1, "R8");   // wrap to FF
    step(9, 'h81, 'h00, 'h01, 1, "R9");
    step(10, 'h01, 'h00, 'h80, 1, "R9");
    step(11, 'h81, 'h00, 'h01, 1, "R9");
    step(12, 'h01, 'h00, 'h01, 1, "R9");
    step(12, 'h02, 'h00, 'h00, 1, "R9");
    step(13, 'h00, 'h80, 'h02, 1, "R10");
    step(14, 'h00, 'hFF, 'h80, 1, "R10");
    step(15, 'h00, 'h00, 'hFF, 1, "R10");
    for (int f = 16; f <= 22; f++) begin
      step(f, 'h3C, 'h00, 'h00, 1, "R11");
      step(f, 'h3C, 'h00, 'hFF, 1, "R11");
    end
    step(25, 'h99, 'h11, 'hA5, 1, "R12");
    step(31, 'h12, 'h34, 'h5A, 1, "R12");
    step(0, 'h12, 'h34, 'hFF, 0, "R2");
    step(1, 'h77, 'h34, 'h00, 0, "R2");
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m++)
        step(0, a, m, (a * 7 + m * 3) & 255, 1, "R3");
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m++)
        step(1, a, m, (a * 5 + m * 11 + 1) & 255, 1, "R4");
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 3)
        step(2, a, m, (a ^ m) & 255, 1, "R5");
    for (int i = 0; i < 3000; i++) begin
      int op;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = int'(lfsr[4:0]);
      step(op, int'(lfsr[15:8]), int'(lfsr[23:16]), int'(lfsr[31:24]),
           lfsr[5] | lfsr[6], tagFor(op));
    end
    step(0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule